// File: doc/BRIEF.md
# Dual Wiper Two-Wire Command Slave

This block is the digital front end of a stereo volume-control chip. It watches an open-drain two-wire bus (clock and data), detects start and stop conditions, and recognises its own slave address. The address is formed from a fixed device code and two strap pins. Once addressed, it interprets a command byte and turns write, read and step operations into single-cycle requests toward two wiper position registers, which live outside this block. For reads it takes the current positions from two input buses.

The block runs on a fast system clock of at least eight times the bus bit rate. Both bus lines are brought into that clock domain through a two-flop chain, and every bus event is derived from the synchronised levels. The block never drives the data line high. It asserts an output-enable that pulls the line low for an acknowledge bit or for a zero data bit.

A step command changes how the bus is read. After the step command is acknowledged, byte framing stops. Every later clock pulse on the bus moves the selected wipers by one position, and the data level during that pulse chooses the direction. This lasts until the next stop or start.

Top module: `wiper_bus_slave`

## Requirements
- R1: After reset the data line is released (`sda_oe_o`=0) and no write or step request is issued while the bus stays idle.
- R2: The address byte is received MSB first as 0,1,0,1,0, then strap bit 1, strap bit 0, then the direction bit (0 write, 1 read). On a match the slave holds `sda_oe_o` high through the ninth clock pulse as the acknowledge.
- R3: An address byte that does not match gets no acknowledge. Every later byte is then ignored, with no acknowledge and no request, until the next start.
- R4: The command byte holds the opcode in bits 7:4, a reserved bit in bit 3, the zero-crossing flag in bit 2, right select in bit 1 and left select in bit 0. Opcode 1010 means write and 0010 means step. Any other opcode, a set reserved bit, or both selects clear gets no acknowledge, and the slave goes idle.
- R5: A write with exactly one select set takes one acknowledged data byte. It issues one `wr_en_o` pulse carrying that select, the low five data bits and the zero-crossing flag. `req_sel_o` bit 0 means left and bit 1 means right.
- R6: A write with both selects set takes two acknowledged data bytes. It issues a left request (`req_sel_o`=01) for the first byte and then a right request (`req_sel_o`=10) for the second. A third byte gets no acknowledge.
- R7: In read mode the slave sends the left position and then the right position, each as three zero bits followed by the five-bit value, MSB first, pulling the line low for every zero bit.
- R8: If the master does not acknowledge a read byte, the slave releases the line and sends nothing more until the next start.
- R9: In step mode each complete clock pulse (rise then fall) issues one `step_en_o` pulse after the falling edge. The pulse carries `step_up_o` equal to the data level seen at the rising edge, the selects and the zero-crossing flag. The clock pulse that ends in a stop issues no step.
- R10: A start at any point restarts address reception. A stop at any point releases the line and returns the slave to idle, so a data byte sent after it without a new start is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the bus bit rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (wired level) |
| strap_i | input | 2 | Address strap pins, bit 1 then bit 0 in the address byte |
| rd_left_i | input | WIPER_W | Current left wiper position for reads |
| rd_right_i | input | WIPER_W | Current right wiper position for reads |
| sda_oe_o | output | 1 | Pull the data line low when 1 |
| wr_en_o | output | 1 | One-cycle wiper write request |
| step_en_o | output | 1 | One-cycle wiper step request |
| step_up_o | output | 1 | Step direction, 1 toward the top of the range |
| req_sel_o | output | 2 | Wiper select of the request: bit 0 left, bit 1 right |
| req_zd_o | output | 1 | Zero-crossing switching flag from the command byte |
| wr_data_o | output | WIPER_W | New wiper value of a write request |

## Verification
The bench drives real bus waveforms. It covers single writes to each side with the zero-crossing flag both set and clear, and a dual write followed by a surplus byte, which shows the ordering of the two requests and where the sequence ends. Wrong device codes, wrong strap bits and three kinds of malformed command byte separate the decode and acknowledge paths from the idle-until-start behaviour. Reads with the master acknowledging and not acknowledging show both the bit order of the returned data and the release of the line. Step bursts in both directions, on one wiper and on both, are each closed by a stop. Repeated starts and early stops check that the protocol state restarts from any point.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_DATA,
    PH_READ,
    PH_STEP
  } phase_e;

  localparam logic [3:0] DEV_CODE = 4'b0101;
  localparam logic [3:0] OP_WRITE = 4'b1010;
  localparam logic [3:0] OP_STEP  = 4'b0010;
  localparam logic [1:0] SEL_LEFT  = 2'b01;
  localparam logic [1:0] SEL_RIGHT = 2'b10;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/wbs_bus_sync.sv
module wbs_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic             scl_q, sda_q;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;
      else         chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= synced[1];
      sda_q <= synced[0];
    end
  end

  assign sda_o      = synced[0];
  assign scl_rise_o = synced[1] & ~scl_q;
  assign scl_fall_o = ~synced[1] & scl_q;
  // line changes while the clock is held high mark frame boundaries
  assign start_o    = synced[1] & scl_q & sda_q & ~synced[0];
  assign stop_o     = synced[1] & scl_q & ~sda_q & synced[0];
endmodule

// File: rtl/wbs_engine.sv
module wbs_engine
  import wbs_pkg::*;
#(
  parameter int unsigned WIPER_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sda_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [1:0]         strap_i,
  input  logic [WIPER_W-1:0] rd_left_i,
  input  logic [WIPER_W-1:0] rd_right_i,
  output logic               sda_oe_o,
  output logic               wr_en_o,
  output logic               step_en_o,
  output logic               step_up_o,
  output logic [1:0]         req_sel_o,
  output logic               req_zd_o,
  output logic [WIPER_W-1:0] wr_data_o
);
  localparam int unsigned PAD_W = BYTE_W - WIPER_W;
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  phase_e             phase_q, next_q, nxt;
  logic [CNT_W-1:0]   bit_cnt_q;
  logic [BYTE_W-1:0]  shreg_q, tx_q, tx_right;
  logic               ack_slot_q, go_q, tx_right_q, mack_q;
  logic               both_q, tgt_right_q, zd_q, dir_q;
  logic [1:0]         sel_q;
  logic               byte_ok;
  logic [3:0]         op;
  logic [2:0]         tx_idx;

  assign op       = shreg_q[7:4];
  assign tx_idx   = 3'd7 - bit_cnt_q[2:0];
  assign tx_right = {{PAD_W{1'b0}}, rd_right_i};

  always_comb begin
    byte_ok = 1'b0;
    nxt     = PH_IDLE;
    case (phase_q)
      PH_ADDR: begin
        byte_ok = (shreg_q[7:1] == {DEV_CODE, 1'b0, strap_i});
        nxt     = shreg_q[0] ? PH_READ : PH_CMD;
      end
      PH_CMD: begin
        byte_ok = !shreg_q[3] && (shreg_q[1:0] != 2'b00) &&
                  ((op == OP_WRITE) || (op == OP_STEP));
        nxt     = (op == OP_WRITE) ? PH_DATA : PH_STEP;
      end
      PH_DATA: begin
        byte_ok = 1'b1;
        nxt     = (both_q && !tgt_right_q) ? PH_DATA : PH_IDLE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      next_q      <= PH_IDLE;
      bit_cnt_q   <= '0;
      shreg_q     <= '0;
      tx_q        <= '0;
      ack_slot_q  <= 1'b0;
      go_q        <= 1'b0;
      tx_right_q  <= 1'b0;
      mack_q      <= 1'b0;
      both_q      <= 1'b0;
      tgt_right_q <= 1'b0;
      zd_q        <= 1'b0;
      dir_q       <= 1'b0;
      sel_q       <= '0;
      sda_oe_o    <= 1'b0;
      wr_en_o     <= 1'b0;
      step_en_o   <= 1'b0;
      step_up_o   <= 1'b0;
      req_sel_o   <= '0;
      req_zd_o    <= 1'b0;
      wr_data_o   <= '0;
    end else begin
      wr_en_o   <= 1'b0;
      step_en_o <= 1'b0;
      if (start_i) begin
        phase_q    <= PH_ADDR;
        bit_cnt_q  <= '0;
        ack_slot_q <= 1'b0;
        sda_oe_o   <= 1'b0;
      end else if (stop_i) begin
        phase_q    <= PH_IDLE;
        bit_cnt_q  <= '0;
        ack_slot_q <= 1'b0;
        sda_oe_o   <= 1'b0;
      end else begin
        case (phase_q)
          PH_ADDR, PH_CMD, PH_DATA: begin
            if (scl_rise_i && bit_cnt_q < FULL) begin
              shreg_q   <= {shreg_q[BYTE_W-2:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
            if (scl_fall_i) begin
              if (!ack_slot_q && bit_cnt_q == FULL) begin
                ack_slot_q <= 1'b1;
                sda_oe_o   <= byte_ok;
                go_q       <= byte_ok;
                next_q     <= nxt;
                if (byte_ok) begin
                  case (phase_q)
                    PH_ADDR: begin
                      tx_q       <= {{PAD_W{1'b0}}, rd_left_i};
                      tx_right_q <= 1'b0;
                    end
                    PH_CMD: begin
                      sel_q       <= shreg_q[1:0];
                      zd_q        <= shreg_q[2];
                      both_q      <= &shreg_q[1:0];
                      tgt_right_q <= !shreg_q[0];
                    end
                    default: begin
                      wr_en_o     <= 1'b1;
                      req_sel_o   <= tgt_right_q ? SEL_RIGHT : SEL_LEFT;
                      wr_data_o   <= shreg_q[WIPER_W-1:0];
                      req_zd_o    <= zd_q;
                      tgt_right_q <= 1'b1;
                    end
                  endcase
                end
              end else if (ack_slot_q) begin
                ack_slot_q <= 1'b0;
                bit_cnt_q  <= '0;
                phase_q    <= go_q ? next_q : PH_IDLE;
                sda_oe_o   <= (go_q && next_q == PH_READ) ? ~tx_q[BYTE_W-1] : 1'b0;
              end
            end
          end
          PH_READ: begin
            if (scl_rise_i) begin
              if (ack_slot_q)              mack_q    <= ~sda_i;
              else if (bit_cnt_q < FULL)   bit_cnt_q <= bit_cnt_q + 1'b1;
            end
            if (scl_fall_i) begin
              if (ack_slot_q) begin
                ack_slot_q <= 1'b0;
                bit_cnt_q  <= '0;
                if (mack_q && !tx_right_q) begin
                  tx_right_q <= 1'b1;
                  tx_q       <= tx_right;
                  sda_oe_o   <= ~tx_right[BYTE_W-1];
                end else begin
                  phase_q  <= PH_IDLE;
                  sda_oe_o <= 1'b0;
                end
              end else if (bit_cnt_q == FULL) begin
                sda_oe_o   <= 1'b0;
                ack_slot_q <= 1'b1;
              end else begin
                sda_oe_o <= ~tx_q[tx_idx];
              end
            end
          end
          PH_STEP: begin
            if (scl_rise_i) dir_q <= sda_i;
            if (scl_fall_i) begin
              step_en_o <= 1'b1;
              step_up_o <= dir_q;
              req_sel_o <= sel_q;
              req_zd_o  <= zd_q;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // acknowledge and data drive only start just after a clock fall
  assert_drive_after_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall_i));

  assert_idle_released_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE) |-> !sda_oe_o);

  assert_write_one_side_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ($countones(req_sel_o) == 1));

  assert_step_only_in_mode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en_o |-> $past(phase_q == PH_STEP));

  assert_single_request_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && step_en_o));

  assert_read_ack_slot_released_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_READ && ack_slot_q) |-> !sda_oe_o);
endmodule

// File: rtl/wiper_bus_slave.sv
module wiper_bus_slave #(
  parameter int unsigned WIPER_W     = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [1:0]         strap_i,
  input  logic [WIPER_W-1:0] rd_left_i,
  input  logic [WIPER_W-1:0] rd_right_i,
  output logic               sda_oe_o,
  output logic               wr_en_o,
  output logic               step_en_o,
  output logic               step_up_o,
  output logic [1:0]         req_sel_o,
  output logic               req_zd_o,
  output logic [WIPER_W-1:0] wr_data_o
);
  logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  wbs_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  wbs_engine #(.WIPER_W(WIPER_W)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (bus_start),
    .stop_i     (bus_stop),
    .strap_i    (strap_i),
    .rd_left_i  (rd_left_i),
    .rd_right_i (rd_right_i),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en_o),
    .step_en_o  (step_en_o),
    .step_up_o  (step_up_o),
    .req_sel_o  (req_sel_o),
    .req_zd_o   (req_zd_o),
    .wr_data_o  (wr_data_o)
  );
endmodule

// File: tb/wiper_bus_slave_bench.sv
module wiper_bus_slave_bench;
  localparam int H = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic [4:0] rd_left = 5'h0B, rd_right = 5'h16;
  logic       sda_oe, wr_en, step_en, step_up, req_zd;
  logic [1:0] req_sel;
  logic [4:0] wr_data;
  wire        sda_line = sda_m & ~sda_oe;

  wiper_bus_slave u_wiper_bus_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .rd_left_i(rd_left), .rd_right_i(rd_right),
    .sda_oe_o(sda_oe), .wr_en_o(wr_en), .step_en_o(step_en),
    .step_up_o(step_up), .req_sel_o(req_sel), .req_zd_o(req_zd),
    .wr_data_o(wr_data)
  );

  int n_chk = 0, n_bad = 0;

  // request log: kind 1 = write, 2 = step
  logic [1:0] ev_kind [128];
  logic [1:0] ev_sel  [128];
  logic [4:0] ev_data [128];
  logic       ev_zd   [128];
  logic       ev_up   [128];
  int         ev_n = 0;

  always @(negedge clk) begin
    if (wr_en || step_en) begin
      if (ev_n < 128) begin
        ev_kind[ev_n] = wr_en ? 2'd1 : 2'd2;
        ev_sel[ev_n]  = req_sel;
        ev_data[ev_n] = wr_data;
        ev_zd[ev_n]   = req_zd;
        ev_up[ev_n]   = step_up;
      end
      ev_n = ev_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    tick(H/2); sda_m = 1'b1; tick(H/2); scl_m = 1'b1;
    tick(H/2); sda_m = 1'b0; tick(H/2); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(H/2); sda_m = 1'b0; tick(H/2); scl_m = 1'b1;
    tick(H/2); sda_m = 1'b1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      tick(H/2); sda_m = v[i]; tick(H/2); scl_m = 1'b1; tick(H); scl_m = 1'b0;
    end
    tick(H/2); sda_m = 1'b1; tick(H/2); scl_m = 1'b1;
    tick(H/2); ack = (sda_line == 1'b0); tick(H/2); scl_m = 1'b0;
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      tick(H/2); sda_m = 1'b1; tick(H/2); scl_m = 1'b1;
      tick(H/2); v[i] = sda_line; tick(H/2); scl_m = 1'b0;
    end
    tick(H/2); sda_m = !mack; tick(H/2); scl_m = 1'b1; tick(H); scl_m = 1'b0;
    tick(2); sda_m = 1'b1;
  endtask

  task automatic step_pulse(input bit up);
    tick(H/2); sda_m = up; tick(H/2); scl_m = 1'b1; tick(H); scl_m = 1'b0;
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
    chk(ev_n == 0, "R1 no requests", ev_n, 0);
  endtask

  task automatic t_write_single(input logic [7:0] cmd, input logic [4:0] d,
                                input logic [1:0] sel, input bit zd);
    bit a; int b;
    b = ev_n;
    bus_start();
    send_byte(8'h54, a); chk(a, "R2 address ack", a, 1);
    send_byte(cmd, a);   chk(a, "R4 command ack", a, 1);
    send_byte({3'b000, d}, a); chk(a, "R5 data ack", a, 1);
    bus_stop(); tick(10);
    chk(ev_n == b + 1, "R5 one write", ev_n - b, 1);
    chk(ev_kind[b] == 2'd1, "R5 kind write", ev_kind[b], 1);
    chk(ev_sel[b] == sel, "R5 select", ev_sel[b], sel);
    chk(ev_data[b] == d, "R5 data", ev_data[b], d);
    chk(ev_zd[b] == zd, "R5 zero flag", ev_zd[b], zd);
  endtask

  task automatic t_write_both();
    bit a; int b;
    b = ev_n;
    bus_start();
    send_byte(8'h54, a); chk(a, "R6 address ack", a, 1);
    send_byte(8'hA3, a); chk(a, "R6 command ack", a, 1);
    send_byte(8'h05, a); chk(a, "R6 left data ack", a, 1);
    send_byte(8'h1A, a); chk(a, "R6 right data ack", a, 1);
    send_byte(8'h07, a); chk(!a, "R6 surplus byte nack", a, 0);
    bus_stop(); tick(10);
    chk(ev_n == b + 2, "R6 two writes", ev_n - b, 2);
    chk(ev_sel[b] == 2'b01 && ev_data[b] == 5'h05, "R6 left first", {ev_sel[b], ev_data[b]}, 7'h25);
    chk(ev_sel[b+1] == 2'b10 && ev_data[b+1] == 5'h1A, "R6 right second",
        {ev_sel[b+1], ev_data[b+1]}, 7'h5A);
  endtask

  task automatic t_bad_address(input logic [7:0] addr);
    bit a; int b;
    b = ev_n;
    bus_start();
    send_byte(addr, a);  chk(!a, "R3 address nack", a, 0);
    send_byte(8'hA5, a); chk(!a, "R3 later byte ignored", a, 0);
    send_byte(8'h11, a); chk(!a, "R3 data ignored", a, 0);
    bus_stop(); tick(10);
    chk(ev_n == b, "R3 no request", ev_n - b, 0);
  endtask

  task automatic t_bad_cmd(input logic [7:0] cmd);
    bit a; int b;
    b = ev_n;
    bus_start();
    send_byte(8'h54, a); chk(a, "R4 address ack", a, 1);
    send_byte(cmd, a);   chk(!a, "R4 invalid command nack", a, 0);
    send_byte(8'h0C, a); chk(!a, "R4 idle after bad command", a, 0);
    bus_stop(); tick(10);
    chk(ev_n == b, "R4 no request", ev_n - b, 0);
  endtask

  task automatic t_read();
    bit a; logic [7:0] v;
    bus_start();
    send_byte(8'h55, a); chk(a, "R7 read address ack", a, 1);
    read_byte(1'b1, v);  chk(v == 8'h0B, "R7 left byte", v, 8'h0B);
    read_byte(1'b1, v);  chk(v == 8'h16, "R7 right byte", v, 8'h16);
    tick(4); chk(sda_oe == 1'b0, "R7 released after right", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_read_nack();
    bit a; logic [7:0] v;
    bus_start();
    send_byte(8'h55, a); chk(a, "R8 read address ack", a, 1);
    read_byte(1'b0, v);  chk(v == 8'h0B, "R8 left byte", v, 8'h0B);
    read_byte(1'b1, v);  chk(v == 8'hFF, "R8 no data after nack", v, 8'hFF);
    bus_stop();
  endtask

  task automatic t_step(input logic [7:0] cmd, input logic [1:0] sel, input bit zd,
                        input int n_up, input int n_dn);
    bit a; int b;
    b = ev_n;
    bus_start();
    send_byte(8'h54, a); chk(a, "R9 address ack", a, 1);
    send_byte(cmd, a);   chk(a, "R9 step command ack", a, 1);
    for (int i = 0; i < n_up; i++) step_pulse(1'b1);
    for (int i = 0; i < n_dn; i++) step_pulse(1'b0);
    bus_stop(); tick(10);
    chk(ev_n == b + n_up + n_dn, "R9 step count", ev_n - b, n_up + n_dn);
    for (int i = 0; i < n_up + n_dn; i++) begin
      chk(ev_kind[b+i] == 2'd2, "R9 kind step", ev_kind[b+i], 2);
      chk(ev_up[b+i] == (i < n_up), "R9 direction", ev_up[b+i], (i < n_up));
      chk(ev_sel[b+i] == sel && ev_zd[b+i] == zd, "R9 select and flag",
          {ev_sel[b+i], ev_zd[b+i]}, {sel, zd});
    end
  endtask

  task automatic t_restart();
    bit a; logic [7:0] v; int b;
    b = ev_n;
    bus_start();
    send_byte(8'h54, a); chk(a, "R10 address ack", a, 1);
    send_byte(8'hA1, a); chk(a, "R10 command ack", a, 1);
    bus_start();
    send_byte(8'h55, a); chk(a, "R10 repeated start address ack", a, 1);
    read_byte(1'b0, v);  chk(v == 8'h0B, "R10 read after restart", v, 8'h0B);
    bus_stop();
    bus_start();
    send_byte(8'h54, a); chk(a, "R10 address ack 2", a, 1);
    send_byte(8'hA2, a); chk(a, "R10 command ack 2", a, 1);
    bus_stop(); tick(4);
    chk(sda_oe == 1'b0, "R10 released after stop", sda_oe, 0);
    send_byte(8'h09, a); chk(!a, "R10 data after stop nack", a, 0);
    bus_stop(); tick(10);
    chk(ev_n == b, "R10 no request", ev_n - b, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(20);
    t_reset();
    t_write_single(8'hA5, 5'h13, 2'b01, 1'b1);
    t_write_single(8'hA2, 5'h1F, 2'b10, 1'b0);
    t_write_both();
    t_bad_address(8'h56);
    t_bad_address(8'h44);
    t_bad_cmd(8'hA0);
    t_bad_cmd(8'hA9);
    t_bad_cmd(8'h33);
    t_read();
    t_read_nack();
    t_step(8'h27, 2'b11, 1'b1, 3, 2);
    t_step(8'h21, 2'b01, 1'b0, 1, 1);
    t_restart();
    finish_run();
  end
endmodule